// File: doc/BRIEF.md
# Sixteen-Bit ALU with Status Flags

A two-operand arithmetic-logic unit for a small 16-bit register machine. The destination register value enters as `dst_a` and is also the first operand. The source register value enters as `src_b`. An 8-bit operation code selects the function. The result, together with a write-back enable, appears combinationally in the same cycle. This lets the surrounding datapath write the value into the destination register at the next clock edge.

A clocked status register holds three flags: carry, overflow and zero. On each clock edge where `exec_en` is high, the flags change, and each operation touches only its own set of flags. Add and subtract refresh all three flags. The arithmetic left shift refreshes overflow and zero. Every other operation refreshes only zero. Flags an operation does not touch keep their value. The `flags` output is the current status word, so the datapath can copy it into a register.

Top module: `alu16_flags`

## Requirements
- R1: Opcode 0x01 gives `dst_a + src_b` modulo 2^16. The carry flag takes the unsigned carry out. The overflow flag is set when both operands have the same sign and the result sign differs.
- R2: Opcode 0x02 gives `dst_a - src_b` modulo 2^16. The carry flag is set on borrow, that is when `dst_a < src_b` unsigned. The overflow flag is set when the operand signs differ and the result sign differs from `dst_a`.
- R3: Opcode 0x03 gives the low 16 bits of the unsigned product.
- R4: Opcodes 0x04, 0x05 and 0x06 give the bitwise AND, OR and XOR of the two operands. Opcode 0x07 gives the bitwise inverse of `src_b`.
- R5: Opcodes 0x08 and 0x09 shift `dst_a` left or right, filling with zeros. The shift amount is the low 4 bits of `src_b`, and all higher bits of `src_b` are ignored.
- R6: Opcode 0x0B shifts `dst_a` right by the low 4 bits of `src_b` and fills the vacated bits with the original bit 15.
- R7: Opcode 0x0A shifts `dst_a` left by the low 4 bits of `src_b`. It sets overflow when any bit shifted out, or the new bit 15, differs from the original bit 15, and clears overflow otherwise. It leaves carry unchanged.
- R8: Opcode 0x0C passes `src_b` to the result.
- R9: For every opcode from 0x01 to 0x0C executed with `exec_en` high, the zero flag becomes 1 at the next clock edge if the result was 0x0000, and 0 otherwise.
- R10: Carry changes only for opcodes 0x01 and 0x02. Overflow changes only for opcodes 0x01, 0x02 and 0x0A.
- R11: Opcode 0x00, and any opcode above 0x0C, keeps `wb_en` low and leaves all flags unchanged. `wb_en` is high for opcodes 0x01 to 0x0C while `exec_en` is high.
- R12: While `exec_en` is low, `wb_en` is low and the flags hold.
- R13: Asynchronous active-low reset clears all flags. In `flags`, bit 0 is carry, bit 1 is overflow and bit 2 is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe for the current operation |
| op | input | 8 | Operation code |
| dst_a | input | 16 | Destination register value, first operand |
| src_b | input | 16 | Source register value, second operand |
| result | output | 16 | Operation result |
| wb_en | output | 1 | Write the result into the destination register |
| flags | output | 3 | Status word: bit 2 zero, bit 1 overflow, bit 0 carry |

## Verification
The properties assume that `op`, `dst_a` and `src_b` are settled a full half cycle before each rising edge. They also assume that the flags are judged only against the operation present at that edge. The stimulus therefore changes inputs only on falling edges, holds `exec_en` high for exactly one rising edge per operation, and drops it between operations. The vector table is walked in order, so each expected flag word accounts for the bits carried over from the previous row. This covers the rows where carry or overflow must survive an operation that updates only zero.

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int W = 16,
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_en,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   dst_a,
  input  logic [W-1:0]   src_b,
  output logic [W-1:0]   result,
  output logic           wb_en,
  output logic [2:0]     flags
);
  localparam int SHW = $clog2(W);
  localparam logic [OPW-1:0] OP_ADD = 'h01, OP_SUB = 'h02, OP_MUL = 'h03,
    OP_AND = 'h04, OP_OR = 'h05, OP_XOR = 'h06, OP_NOT = 'h07, OP_SHL = 'h08,
    OP_SHR = 'h09, OP_SLA = 'h0A, OP_SRA = 'h0B, OP_MOV = 'h0C;

  logic [SHW-1:0] sh;
  logic [W:0]     sum, diff;
  logic [W-1:0]   prod, sla_r, sla_back;
  logic           c_q, v_q, z_q;
  logic           c_n, v_n;
  logic           upd_c, upd_v;

  assign sh       = src_b[SHW-1:0];
  assign sum      = {1'b0, dst_a} + {1'b0, src_b};
  assign diff     = {1'b0, dst_a} - {1'b0, src_b};
  assign prod     = dst_a * src_b;
  assign sla_r    = dst_a << sh;
  assign sla_back = $signed(sla_r) >>> sh;

  assign wb_en = exec_en && (op >= OP_ADD) && (op <= OP_MOV);
  assign upd_c = exec_en && (op == OP_ADD || op == OP_SUB);
  assign upd_v = upd_c || (exec_en && op == OP_SLA);

  always_comb begin
    result = '0;
    c_n    = c_q;
    v_n    = v_q;
    case (op)
      OP_ADD: begin
        result = sum[W-1:0];
        c_n    = sum[W];
        v_n    = (dst_a[W-1] == src_b[W-1]) && (sum[W-1] != dst_a[W-1]);
      end
      OP_SUB: begin
        result = diff[W-1:0];
        c_n    = diff[W];
        v_n    = (dst_a[W-1] != src_b[W-1]) && (diff[W-1] != dst_a[W-1]);
      end
      OP_MUL: result = prod;
      OP_AND: result = dst_a & src_b;
      OP_OR:  result = dst_a | src_b;
      OP_XOR: result = dst_a ^ src_b;
      OP_NOT: result = ~src_b;
      OP_SHL: result = dst_a << sh;
      OP_SHR: result = dst_a >> sh;
      OP_SLA: begin
        result = sla_r;
        v_n    = (sla_back != dst_a);
      end
      OP_SRA: result = $signed(dst_a) >>> sh;
      OP_MOV: result = src_b;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      v_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      if (upd_c) c_q <= c_n;
      if (upd_v) v_q <= v_n;
      if (wb_en) z_q <= (result == '0);
    end
  end

  assign flags = {z_q, v_q, c_q};

  assert_no_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == '0 || op > OP_MOV) |-> !wb_en);
  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(flags));
  assert_carry_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op >= OP_MUL) |=> $stable(flags[0]));
  assert_ovf_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op != OP_ADD && op != OP_SUB && op != OP_SLA) |=> $stable(flags[1]));
  assert_zero_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> (flags[2] == ($past(result) == '0)));
endmodule

// File: tb/sim_alu16_flags.sv
module sim_alu16_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [7:0]  op = '0;
  logic [15:0] dst_a = '0, src_b = '0;
  logic [15:0] result;
  logic        wb_en;
  logic [2:0]  flags;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  alu16_flags u0 (.clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op),
    .dst_a(dst_a), .src_b(src_b), .result(result), .wb_en(wb_en), .flags(flags));

  // {op, dst_a, src_b, expected result, expected flags {z,v,c}}, walked in order
  localparam int NV = 21;
  localparam logic [58:0] VEC [NV] = '{
    {8'h01, 16'h0001, 16'h0002, 16'h0003, 3'b000},
    {8'h01, 16'hFFFF, 16'h0001, 16'h0000, 3'b101},
    {8'h01, 16'h7FFF, 16'h0001, 16'h8000, 3'b010},
    {8'h02, 16'h0005, 16'h0007, 16'hFFFE, 3'b001},
    {8'h02, 16'h8000, 16'h0001, 16'h7FFF, 3'b010},
    {8'h03, 16'h0100, 16'h0100, 16'h0000, 3'b110},
    {8'h03, 16'h0003, 16'h0005, 16'h000F, 3'b010},
    {8'h04, 16'hF0F0, 16'h0F0F, 16'h0000, 3'b110},
    {8'h05, 16'hF0F0, 16'h0F0F, 16'hFFFF, 3'b010},
    {8'h06, 16'hAAAA, 16'hAAAA, 16'h0000, 3'b110},
    {8'h07, 16'h1234, 16'h00FF, 16'hFF00, 3'b010},
    {8'h08, 16'h0001, 16'h0014, 16'h0010, 3'b010},
    {8'h09, 16'h8000, 16'h000F, 16'h0001, 3'b010},
    {8'h0B, 16'h8000, 16'h0004, 16'hF800, 3'b010},
    {8'h0A, 16'h0001, 16'h0003, 16'h0008, 3'b000},
    {8'h01, 16'hFFFF, 16'h0001, 16'h0000, 3'b101},
    {8'h0A, 16'h4000, 16'h0001, 16'h8000, 3'b011},
    {8'h0A, 16'h8000, 16'h0001, 16'h0000, 3'b111},
    {8'h0C, 16'h1111, 16'h0000, 16'h0000, 3'b111},
    {8'h09, 16'h00F0, 16'h0004, 16'h000F, 3'b011},
    {8'h0A, 16'hFFF0, 16'h0004, 16'hFF00, 3'b001}
  };

  function automatic string tag_of(input logic [7:0] o);
    case (o)
      8'h01: return "R1";
      8'h02: return "R2";
      8'h03: return "R3";
      8'h04, 8'h05, 8'h06, 8'h07: return "R4";
      8'h08, 8'h09: return "R5";
      8'h0B: return "R6";
      8'h0A: return "R7";
      8'h0C: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] o, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op = o; dst_a = a; src_b = b; exec_en = 1'b1;
    #1;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] held;
    repeat (3) @(negedge clk);
    check(flags == 3'b000, "R13 reset", {13'b0, flags}, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][58:51], VEC[i][50:35], VEC[i][34:19]);
      check(result == VEC[i][18:3], tag_of(VEC[i][58:51]), result, VEC[i][18:3]);
      check(wb_en == 1'b1, "R11 wb_en", {15'b0, wb_en}, 16'h1);
      @(negedge clk);
      check(flags == VEC[i][2:0], "R9 R10 flags", {13'b0, flags}, {13'b0, VEC[i][2:0]});
      exec_en = 1'b0;
    end

    held = flags;
    run_op(8'h00, 16'h0000, 16'h0000);
    check(wb_en == 1'b0, "R11 nop wb", {15'b0, wb_en}, 16'h0);
    @(negedge clk);
    check(flags == held, "R11 nop flags", {13'b0, flags}, {13'b0, held});
    exec_en = 1'b0;

    run_op(8'h0D, 16'h0000, 16'h0000);
    check(wb_en == 1'b0, "R11 unknown wb", {15'b0, wb_en}, 16'h0);
    @(negedge clk);
    check(flags == held, "R11 unknown flags", {13'b0, flags}, {13'b0, held});
    exec_en = 1'b0;

    @(negedge clk);
    op = 8'h01; dst_a = 16'h0000; src_b = 16'h0000; exec_en = 1'b0;
    #1;
    check(wb_en == 1'b0, "R12 idle wb", {15'b0, wb_en}, 16'h0);
    repeat (2) @(negedge clk);
    check(flags == held, "R12 idle flags", {13'b0, flags}, {13'b0, held});

    run_op(8'h08, 16'h0003, 16'hFFF1);
    check(result == 16'h0006, "R5 amount low bits", result, 16'h0006);
    @(negedge clk);
    exec_en = 1'b0;

    run_op(8'h01, 16'hFFFF, 16'h0001);
    @(negedge clk);
    exec_en = 1'b0;
    check(flags == 3'b101, "R1 carry set", {13'b0, flags}, 16'h5);
    rst_n = 1'b0;
    #1;
    check(flags == 3'b000, "R13 async reset", {13'b0, flags}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule